// File: doc/BRIEF.md
# Restart Opcode Priority Encoder

This block merges eight device interrupt requests onto the single non-vectored interrupt line of an 8-bit processor. It raises a combined request whenever any device line is active. When the processor answers with an interrupt-acknowledge strobe, the block picks the highest-numbered active request. It then drives a one-byte restart opcode whose middle field carries the winning number, so the processor jumps straight to that device's service entry.

The winner is chosen and held by a two-state machine. `ST_IDLE` is the state outside an acknowledge. The transition `CAPTURE` (ST_IDLE to ST_HOLD) fires on the first clock edge at which the strobe is high, and latches the winning index and a found-request flag. `ST_HOLD` keeps that capture while the strobe stays high. The transition `RELEASE` (ST_HOLD to ST_IDLE) fires on the first edge at which the strobe is low. During the first clock cycle of a strobe, before the capture edge, the output follows the live encoding, so the byte is on the bus as soon as the strobe rises. The bus-drive output stands in for the enable of a tri-state buffer. The priority order is wired in and cannot be changed.

Top module: `rst_opcode_gen`

## Requirements
- R1: `int_o` is high exactly when at least one bit of `req_i` is high, combinationally and in every cycle, whether or not an acknowledge is in progress.
- R2: Priority rises with the input number: of the active requests, the one with the largest index wins (input 7 highest, input 0 lowest).
- R3: The winning index, as a 3-bit unsigned number, appears in `op_o[5:3]` while `drive_o` is high.
- R4: While `drive_o` is high, every other opcode bit is 1, so `op_o` has the form 11xxx111 in binary (0xC7 plus 8 times the index).
- R5: The opcode is captured at the first rising clock edge at which `ack_i` is high. From that edge it holds its value for the rest of the strobe, even when `req_i` changes.
- R6: While `ack_i` is low, `drive_o` and `valid_o` are low and `op_o` is 0x00.
- R7: While `ack_i` is high, `valid_o` is high exactly when at least one request was active when the opcode was chosen. If none was active, `op_o` is 0xC7 with `valid_o` low.
- R8: Each new strobe, meaning `ack_i` going low and then high again, makes a fresh choice from the requests present at that time.
- R9: After reset, with `ack_i` low, all acknowledge-side outputs are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Device request lines, bit n is device n |
| ack_i | input | 1 | Interrupt-acknowledge strobe, active high |
| int_o | output | 1 | Combined interrupt request to the processor |
| op_o | output | 8 | Restart opcode, 0x00 when not driving |
| drive_o | output | 1 | Bus-drive enable, models a tri-state buffer |
| valid_o | output | 1 | A real request produced the opcode |

## Verification
The bench builds the block with its default of eight request lines. At that size all 256 request patterns can be swept. For each pattern it runs a complete acknowledge strobe, checks the opcode against the highest set bit found arithmetically, then inverts the requests mid-strobe to show that the capture holds. Because successive strobes carry different patterns, every sweep step also checks that a new strobe makes a fresh choice. A longer strobe with several request changes covers holding over many cycles.

// File: rtl/rog_pkg.sv
package rog_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } ack_state_t;

    localparam int OP_WIDTH = 8;
endpackage

// File: rtl/rog_prio_enc.sv
module rog_prio_enc #(
    parameter int N_REQ = 8,
    localparam int IDX_W = $clog2(N_REQ)
) (
    input  logic [N_REQ-1:0] req,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    logic [N_REQ-1:0] win;

    // A line wins when it is active and no higher-numbered line is.
    genvar g;
    generate
        for (g = 0; g < N_REQ; g++) begin : g_win
            if (g == N_REQ - 1) begin : g_top
                assign win[g] = req[g];
            end else begin : g_low
                assign win[g] = req[g] & ~(|req[N_REQ-1:g+1]);
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (win[i]) idx = idx | IDX_W'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/rog_ack_fsm.sv
module rog_ack_fsm #(
    parameter int N_REQ = 8,
    localparam int IDX_W = $clog2(N_REQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic [IDX_W-1:0] live_idx,
    input  logic             live_any,
    output logic [IDX_W-1:0] sel_idx,
    output logic             sel_any,
    output logic             drive
);
    import rog_pkg::*;

    ack_state_t       state_q, state_d;
    logic [IDX_W-1:0] held_idx_q;
    logic             held_any_q;

    // Next state: CAPTURE on strobe, RELEASE when the strobe drops
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ack)  state_d = ST_HOLD;
            ST_HOLD: if (!ack) state_d = ST_IDLE;
            default:           state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture register, loaded on CAPTURE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_idx_q <= '0;
            held_any_q <= 1'b0;
        end else if (state_q == ST_IDLE && ack) begin
            held_idx_q <= live_idx;
            held_any_q <= live_any;
        end
    end

    // Outputs: live choice before the capture edge, held choice after it
    always_comb begin
        sel_idx = live_idx;
        sel_any = live_any;
        unique case (state_q)
            ST_IDLE: begin
                sel_idx = live_idx;
                sel_any = live_any;
            end
            ST_HOLD: begin
                sel_idx = held_idx_q;
                sel_any = held_any_q;
            end
            default: begin
                sel_idx = live_idx;
                sel_any = live_any;
            end
        endcase
        drive = ack;
    end
endmodule

// File: rtl/rst_opcode_gen.sv
module rst_opcode_gen #(
    parameter int N_REQ   = 8,
    parameter int IDX_LSB = 3,
    localparam int IDX_W  = $clog2(N_REQ),
    localparam int OP_W   = rog_pkg::OP_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    input  logic             ack_i,
    output logic             int_o,
    output logic [OP_W-1:0]  op_o,
    output logic             drive_o,
    output logic             valid_o
);
    logic [IDX_W-1:0] live_idx, sel_idx;
    logic             live_any, sel_any, drive;

    rog_prio_enc #(.N_REQ(N_REQ)) u_enc (
        .req (req_i),
        .idx (live_idx),
        .any (live_any)
    );

    rog_ack_fsm #(.N_REQ(N_REQ)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack      (ack_i),
        .live_idx (live_idx),
        .live_any (live_any),
        .sel_idx  (sel_idx),
        .sel_any  (sel_any),
        .drive    (drive)
    );

    // Restart opcode: all ones with the index in its field
    always_comb begin
        op_o = '0;
        if (drive) begin
            op_o = '1;
            op_o[IDX_LSB +: IDX_W] = sel_idx;
        end
    end

    assign int_o   = live_any;
    assign drive_o = drive;
    assign valid_o = drive & sel_any;
endmodule

// File: rtl/rog_checker.sv
module rog_checker #(
    parameter int N_REQ   = 8,
    parameter int IDX_LSB = 3,
    parameter int IDX_W   = 3,
    parameter int OP_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] req_i,
    input logic             ack_i,
    input logic             int_o,
    input logic [OP_W-1:0]  op_o,
    input logic             drive_o,
    input logic             valid_o
);
    logic [IDX_W-1:0] idx_seen;
    assign idx_seen = op_o[IDX_LSB +: IDX_W];

    AST_INT_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        int_o == (req_i != '0)); // R1

    AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !$past(ack_i) && $past(rst_n) && (req_i != '0))
        |-> (req_i[idx_seen] && ((req_i >> idx_seen) == 1))); // R2

    AST_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |-> ((op_o | (((1 << IDX_W) - 1) << IDX_LSB)) == {OP_W{1'b1}})); // R4

    AST_HOLD_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && $past(ack_i) && $past(rst_n)) |-> ($stable(op_o) && $stable(valid_o))); // R5

    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |-> (op_o == '0 && !drive_o && !valid_o)); // R6

    AST_VALID_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !$past(ack_i) && $past(rst_n)) |-> (valid_o == (req_i != '0))); // R7
endmodule

bind rst_opcode_gen rog_checker #(
    .N_REQ   (N_REQ),
    .IDX_LSB (IDX_LSB),
    .IDX_W   (IDX_W),
    .OP_W    (OP_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .ack_i   (ack_i),
    .int_o   (int_o),
    .op_o    (op_o),
    .drive_o (drive_o),
    .valid_o (valid_o)
);

// File: tb/tb_rst_opcode_gen.sv
module tb_rst_opcode_gen;
    localparam int CLK_T = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0;
    logic       ack_i = 1'b0;
    logic       int_o, drive_o, valid_o;
    logic [7:0] op_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    rst_opcode_gen dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .ack_i   (ack_i),
        .int_o   (int_o),
        .op_o    (op_o),
        .drive_o (drive_o),
        .valid_o (valid_o)
    );

    always #(CLK_T/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Highest set bit by repeated halving; 0xC7 plus 8 times it
    function automatic int exp_op(input int p);
        int v = p;
        int hi = 0;
        while (v > 1) begin
            v = v / 2;
            hi++;
        end
        return 199 + 8 * hi;
    endfunction

    initial begin
        #(CLK_T * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R9 op",    op_o,    0);
        chk("R9 drive", drive_o, 0);
        chk("R9 valid", valid_o, 0);

        for (int p = 0; p < 256; p++) begin
            @(negedge clk);
            req_i = 8'(p);
            ack_i = 1'b0;
            #1;
            chk("R1 idle int", int_o, (p != 0) ? 1 : 0);
            chk("R6 idle op", op_o, 0);
            chk("R6 idle drive/valid", {drive_o, valid_o}, 0);

            @(negedge clk);
            ack_i = 1'b1;
            #1;
            chk("R2 R3 R4 R8 opcode", op_o, exp_op(p));
            chk("R7 valid at rise", valid_o, (p != 0) ? 1 : 0);
            chk("R6 drive on", drive_o, 1);

            @(negedge clk);
            req_i = ~8'(p);
            #1;
            chk("R5 held opcode", op_o, exp_op(p));
            chk("R5 R7 held valid", valid_o, (p != 0) ? 1 : 0);
            chk("R1 live int", int_o, (p != 255) ? 1 : 0);

            @(negedge clk);
            ack_i = 1'b0;
            #1;
            chk("R6 after strobe", {op_o, drive_o, valid_o}, 0);
        end

        // Long strobe: several request changes, capture still held
        @(negedge clk);
        req_i = 8'h24;
        ack_i = 1'b1;
        #1;
        chk("R2 long start", op_o, 8'hEF);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            req_i = 8'(8'h80 >> k);
            #1;
            chk("R5 long hold", op_o, 8'hEF);
            chk("R5 long valid", valid_o, 1);
        end
        @(negedge clk);
        ack_i = 1'b0;
        req_i = 8'h00;
        @(negedge clk);
        ack_i = 1'b1;
        #1;
        chk("R7 empty opcode", op_o, 8'hC7);
        chk("R7 empty valid", valid_o, 0);
        @(negedge clk);
        req_i = 8'h01;
        #1;
        chk("R5 empty held valid", valid_o, 0);
        @(negedge clk);
        ack_i = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule